// File: doc/BRIEF.md
# Root Error Message Collector

This block sits at a root port and accepts error messages that downstream devices have sent toward the root. Each message arrives already decoded, as a message code and the 16-bit requester ID of the sender. It sorts each message into one of two classes, correctable or uncorrectable, and tracks each class with a small state machine. It records whether each class has been seen once or more than once, and it latches the sender ID of only the first message in each class. For the uncorrectable class it also records whether that first message was fatal, and it keeps separate flags for non-fatal and fatal arrivals.

Software reaches three registers through a simple word-addressed port. The command register holds three interrupt enables. The status register holds the received, multiple and severity flags, which software clears by writing 1, and it carries the interrupt vector number in its top bits. The source register holds the two latched sender IDs. The interrupt request is a level. It stays high while an enabled class has its flag set.

Each class tracker has four states. `TRK_EMPTY` means nothing has been received. `TRK_SINGLE` means one message has been received. `TRK_REPEAT` means the first message was followed by more. `TRK_ORPHAN` means the multiple flag remains after software cleared only the received flag. A software clear is applied first in each cycle and a message second. The transitions are: EMPTY to SINGLE on a message, with ID capture. SINGLE to REPEAT on a message. ORPHAN to REPEAT on a message, with ID capture. SINGLE to EMPTY on a clear of received. REPEAT to SINGLE on a clear of multiple. REPEAT to ORPHAN on a clear of received. REPEAT to EMPTY on a clear of both. ORPHAN to EMPTY on a clear of multiple.

Top module: `root_err_collector`

## Requirements
- R1: Message code 8'h30 is correctable, 8'h31 is non-fatal and 8'h33 is fatal. A valid message with any other code changes no register.
- R2: A correctable message while status bit 0 is clear sets bit 0 and latches its sender ID into source register bits [15:0].
- R3: A correctable message while status bit 0 is set sets status bit 1 and leaves source bits [15:0] unchanged.
- R4: A non-fatal or fatal message while status bit 2 is clear sets bit 2 and latches its sender ID into source bits [31:16]. While bit 2 is set, such a message sets bit 3 and leaves source bits [31:16] unchanged.
- R5: When status bit 2 goes from clear to set, bit 4 takes the value 1 if that message was fatal and 0 if it was non-fatal. Later messages do not change bit 4.
- R6: A non-fatal message sets status bit 5 and a fatal message sets status bit 6.
- R7: Status bits [6:0] are write-1-to-clear. The source IDs stay in place after a clear. Clearing bit 0 or bit 2 re-arms ID capture for that class. A message in the same cycle as the clear is treated as a first message.
- R8: Register address 0 is the command register. Bits [2:0] are read-write enables for correctable, non-fatal and fatal, and the other bits read as 0. Address 1 is status, address 2 is the source register, and address 3 reads 0.
- R9: irq is high exactly while (enable bit 0 and status bit 0) or (enable bit 1 and status bit 5) or (enable bit 2 and status bit 6) holds.
- R10: Status bits [31:27] read the irq_vector input, and bits [26:7] read 0.
- R11: After reset the command register, status bits [6:0], the source register and irq are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| msg_valid | input | 1 | A decoded error message is present this cycle |
| msg_code | input | 8 | Message code |
| msg_src_id | input | 16 | Requester ID of the sender |
| irq_vector | input | 5 | Interrupt message number shown in status [31:27] |
| reg_addr | input | 2 | Register word address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | Level interrupt request |

## Verification
A tracker in the wrong state appears on the next status read. It shows as a received or multiple flag that disagrees with the number of messages sent since the last clear. It also shows one message later, as a source ID that is overwritten or not captured. A stuck first-fatal flag or a stuck severity flag appears in status at once and, when enabled, on irq in the same cycle. The orphan state and the case of a clear and a message in the same cycle are each driven on purpose, because only a message that follows them shows whether capture was re-armed.

// File: rtl/err_pkg.sv
package err_pkg;
    localparam int CODE_W = 8;
    localparam int ID_W   = 16;
    localparam int DATA_W = 32;
    localparam int VEC_W  = 5;

    localparam logic [CODE_W-1:0] CODE_COR   = 8'h30;
    localparam logic [CODE_W-1:0] CODE_NONF  = 8'h31;
    localparam logic [CODE_W-1:0] CODE_FATAL = 8'h33;

    // status bit positions (software decodes these)
    localparam int ST_COR_RX   = 0;
    localparam int ST_COR_MUL  = 1;
    localparam int ST_UNC_RX   = 2;
    localparam int ST_UNC_MUL  = 3;
    localparam int ST_FIRST_FT = 4;
    localparam int ST_NF_RX    = 5;
    localparam int ST_FT_RX    = 6;
    localparam int ST_BITS     = 7;

    localparam logic [1:0] ADDR_CMD  = 2'd0;
    localparam logic [1:0] ADDR_STAT = 2'd1;
    localparam logic [1:0] ADDR_SRC  = 2'd2;

    typedef enum logic [1:0] {
        TRK_EMPTY  = 2'd0,
        TRK_SINGLE = 2'd1,
        TRK_REPEAT = 2'd2,
        TRK_ORPHAN = 2'd3
    } trk_state_t;
endpackage

// File: rtl/err_msg_decode.sv
module err_msg_decode
    import err_pkg::*;
(
    input  logic              valid,
    input  logic [CODE_W-1:0] code,
    output logic              hit_cor,
    output logic              hit_nonf,
    output logic              hit_fatal
);
    always_comb begin
        hit_cor   = valid && (code == CODE_COR);
        hit_nonf  = valid && (code == CODE_NONF);
        hit_fatal = valid && (code == CODE_FATAL);
    end
endmodule

// File: rtl/err_class_tracker.sv
module err_class_tracker
    import err_pkg::*;
#(
    parameter int SRC_W = ID_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit,
    input  logic [SRC_W-1:0] src_id,
    input  logic             clr_rx,
    input  logic             clr_mul,
    output logic             seen_rx,
    output logic             seen_mul,
    output logic             capture,
    output logic [SRC_W-1:0] src_q
);
    trk_state_t state_q, base, state_d;

    // clear first, then message
    always_comb begin
        unique case (state_q)
            TRK_EMPTY:  base = TRK_EMPTY;
            TRK_SINGLE: base = clr_rx ? TRK_EMPTY : TRK_SINGLE;
            TRK_REPEAT: begin
                if (clr_rx && clr_mul) base = TRK_EMPTY;
                else if (clr_rx)       base = TRK_ORPHAN;
                else if (clr_mul)      base = TRK_SINGLE;
                else                   base = TRK_REPEAT;
            end
            TRK_ORPHAN: base = clr_mul ? TRK_EMPTY : TRK_ORPHAN;
            default:    base = TRK_EMPTY;
        endcase
        state_d = base;
        capture = 1'b0;
        if (hit) begin
            unique case (base)
                TRK_EMPTY:  begin state_d = TRK_SINGLE; capture = 1'b1; end
                TRK_ORPHAN: begin state_d = TRK_REPEAT; capture = 1'b1; end
                default:    state_d = TRK_REPEAT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TRK_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       src_q <= '0;
        else if (capture) src_q <= src_id;
    end

    always_comb begin
        seen_rx  = (state_q == TRK_SINGLE) || (state_q == TRK_REPEAT);
        seen_mul = (state_q == TRK_REPEAT) || (state_q == TRK_ORPHAN);
    end
endmodule

// File: rtl/root_err_collector.sv
module root_err_collector
    import err_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              msg_valid,
    input  logic [CODE_W-1:0] msg_code,
    input  logic [ID_W-1:0]   msg_src_id,
    input  logic [VEC_W-1:0]  irq_vector,
    input  logic [1:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int NCLS  = 2;
    localparam int PAD_W = DATA_W - VEC_W - ST_BITS;

    logic hit_cor, hit_nonf, hit_fatal;
    logic [NCLS-1:0] cls_hit, cls_clr_rx, cls_clr_mul, cls_rx, cls_mul, cls_cap;
    logic [ID_W-1:0] cls_src [NCLS];
    logic [2:0] cmd_q;
    logic first_fatal_q, nf_q, ft_q;
    logic wr_cmd, wr_stat;
    logic [ST_BITS-1:0] stat_bits;
    logic [DATA_W-1:0]  src_word;
    logic unused_wdata;

    assign unused_wdata = ^reg_wdata[DATA_W-1:ST_BITS];

    err_msg_decode u_dec (
        .valid(msg_valid), .code(msg_code),
        .hit_cor(hit_cor), .hit_nonf(hit_nonf), .hit_fatal(hit_fatal)
    );

    assign wr_cmd  = reg_wr && (reg_addr == ADDR_CMD);
    assign wr_stat = reg_wr && (reg_addr == ADDR_STAT);

    assign cls_hit     = {hit_nonf | hit_fatal, hit_cor};
    assign cls_clr_rx  = {wr_stat & reg_wdata[ST_UNC_RX],  wr_stat & reg_wdata[ST_COR_RX]};
    assign cls_clr_mul = {wr_stat & reg_wdata[ST_UNC_MUL], wr_stat & reg_wdata[ST_COR_MUL]};

    for (genvar g = 0; g < NCLS; g++) begin : g_cls
        err_class_tracker #(.SRC_W(ID_W)) u_trk (
            .clk(clk), .rst_n(rst_n),
            .hit(cls_hit[g]), .src_id(msg_src_id),
            .clr_rx(cls_clr_rx[g]), .clr_mul(cls_clr_mul[g]),
            .seen_rx(cls_rx[g]), .seen_mul(cls_mul[g]),
            .capture(cls_cap[g]), .src_q(cls_src[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_q         <= '0;
            first_fatal_q <= 1'b0;
            nf_q          <= 1'b0;
            ft_q          <= 1'b0;
        end else begin
            if (wr_cmd) cmd_q <= reg_wdata[2:0];
            if (cls_cap[1])                           first_fatal_q <= hit_fatal;
            else if (wr_stat && reg_wdata[ST_FIRST_FT]) first_fatal_q <= 1'b0;
            if (hit_nonf)                             nf_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_NF_RX])  nf_q <= 1'b0;
            if (hit_fatal)                            ft_q <= 1'b1;
            else if (wr_stat && reg_wdata[ST_FT_RX])  ft_q <= 1'b0;
        end
    end

    assign stat_bits = {ft_q, nf_q, first_fatal_q, cls_mul[1], cls_rx[1], cls_mul[0], cls_rx[0]};
    assign src_word  = {cls_src[1], cls_src[0]};

    always_comb begin
        unique case (reg_addr)
            ADDR_CMD:  reg_rdata = {{(DATA_W-3){1'b0}}, cmd_q};
            ADDR_STAT: reg_rdata = {irq_vector, {PAD_W{1'b0}}, stat_bits};
            ADDR_SRC:  reg_rdata = src_word;
            default:   reg_rdata = '0;
        endcase
    end

    assign irq = (cmd_q[0] & cls_rx[0]) | (cmd_q[1] & nf_q) | (cmd_q[2] & ft_q);
endmodule

// File: rtl/err_collector_checks.sv
module err_collector_checks
    import err_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              msg_valid,
    input logic [CODE_W-1:0] msg_code,
    input logic              reg_wr,
    input logic [1:0]        reg_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [ST_BITS-1:0] stat,
    input logic [DATA_W-1:0] srcw,
    input logic              irq
);
    logic wr_st;
    assign wr_st = reg_wr && (reg_addr == ADDR_STAT);

    a_r2_cor_sets_rx: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_code == CODE_COR |=> stat[ST_COR_RX]);

    a_r3_cor_repeat_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_code == CODE_COR && stat[ST_COR_RX] && !(wr_st && reg_wdata[ST_COR_RX])
        |=> stat[ST_COR_MUL] && $stable(srcw[15:0]));

    a_r4_unc_repeat_keeps_id: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && (msg_code == CODE_NONF || msg_code == CODE_FATAL) && stat[ST_UNC_RX]
        && !(wr_st && reg_wdata[ST_UNC_RX])
        |=> stat[ST_UNC_MUL] && $stable(srcw[31:16]));

    a_r1_unknown_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        msg_valid && msg_code != CODE_COR && msg_code != CODE_NONF && msg_code != CODE_FATAL && !reg_wr
        |=> $stable(stat) && $stable(srcw));

    a_r5_first_fatal_origin: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stat[ST_FIRST_FT]) |-> $past(msg_valid && msg_code == CODE_FATAL));

    a_r9_irq_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (stat[ST_COR_RX] || stat[ST_NF_RX] || stat[ST_FT_RX]));
endmodule

bind root_err_collector err_collector_checks u_chk (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_code(msg_code),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .stat(stat_bits), .srcw(src_word), .irq(irq)
);

// File: tb/sim_root_err_collector.sv
module sim_root_err_collector;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msg_valid = 1'b0;
    logic [7:0]  msg_code = '0;
    logic [15:0] msg_src_id = '0;
    logic [4:0]  irq_vector = 5'h13;
    logic [1:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_checks = 0;
    int n_errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    root_err_collector u0 (
        .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_code(msg_code),
        .msg_src_id(msg_src_id), .irq_vector(irq_vector), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic send(input logic [7:0] c, input logic [15:0] id);
        @(negedge clk);
        msg_valid = 1'b1; msg_code = c; msg_src_id = id;
        @(negedge clk);
        msg_valid = 1'b0;
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic expect_state(input string req, input logic [6:0] st, input logic [31:0] src);
        logic [31:0] d;
        rd(2'd1, d); check(req, {25'd0, d[6:0]}, {25'd0, st});
        rd(2'd2, d); check(req, d, src);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(2'd0, d); check("R11 cmd", d, 32'h0);
        rd(2'd1, d); check("R10 R11 status", d, 32'h9800_0000);
        rd(2'd2, d); check("R11 src", d, 32'h0);
        rd(2'd3, d); check("R8 addr3", d, 32'h0);
        check("R11 irq", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_correctable();
        send(8'h30, 16'h1234);
        expect_state("R2 first cor", 7'h01, 32'h0000_1234);
        send(8'h30, 16'hBEEF);
        expect_state("R3 repeat cor", 7'h03, 32'h0000_1234);
        check("R9 irq disabled", {31'd0, irq}, 32'd0);
    endtask

    task automatic t_uncorrectable();
        send(8'h31, 16'h0A0A);
        expect_state("R4 R6 first nonfatal", 7'h27, 32'h0A0A_1234);
        send(8'h33, 16'h0B0B);
        expect_state("R4 R5 R6 repeat fatal", 7'h6F, 32'h0A0A_1234);
    endtask

    task automatic t_clear_and_fatal_first();
        wr(2'd1, 32'hFFFF_FFFF);
        expect_state("R7 w1c sticky ids", 7'h00, 32'h0A0A_1234);
        send(8'h33, 16'h0C0C);
        expect_state("R5 R7 fatal first", 7'h54, 32'h0C0C_1234);
    endtask

    task automatic t_unknown();
        send(8'h32, 16'hDEAD);
        send(8'h00, 16'hFACE);
        expect_state("R1 unknown ignored", 7'h54, 32'h0C0C_1234);
    endtask

    task automatic t_command_irq();
        logic [31:0] d;
        wr(2'd0, 32'hFFFF_FFFF);
        rd(2'd0, d); check("R8 cmd readback", d, 32'h7);
        check("R9 fatal irq", {31'd0, irq}, 32'd1);
        wr(2'd1, 32'h40);
        expect_state("R7 clear fatal bit", 7'h14, 32'h0C0C_1234);
        check("R9 irq drops", {31'd0, irq}, 32'd0);
        wr(2'd0, 32'h1);
        send(8'h31, 16'h0D0D);
        expect_state("R4 repeat nonfatal", 7'h3C, 32'h0C0C_1234);
        check("R9 nonfatal not enabled", {31'd0, irq}, 32'd0);
        send(8'h30, 16'h5555);
        expect_state("R7 cor rearmed", 7'h3D, 32'h0C0C_5555);
        check("R9 cor irq", {31'd0, irq}, 32'd1);
    endtask

    task automatic t_same_cycle();
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = 2'd1; reg_wdata = 32'h1;
        msg_valid = 1'b1; msg_code = 8'h30; msg_src_id = 16'h7777;
        @(negedge clk);
        reg_wr = 1'b0; msg_valid = 1'b0;
        expect_state("R7 clear plus msg", 7'h3D, 32'h0C0C_7777);
    endtask

    task automatic t_orphan();
        send(8'h30, 16'h8888);
        expect_state("R3 multiple", 7'h3F, 32'h0C0C_7777);
        wr(2'd1, 32'h1);
        expect_state("R7 orphan multiple", 7'h3E, 32'h0C0C_7777);
        check("R9 irq after clear", {31'd0, irq}, 32'd0);
        send(8'h30, 16'h9999);
        expect_state("R7 capture from orphan", 7'h3F, 32'h0C0C_9999);
        check("R9 irq again", {31'd0, irq}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_correctable();
        t_uncorrectable();
        t_clear_and_fatal_first();
        t_unknown();
        t_command_irq();
        t_same_cycle();
        t_orphan();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule